// File: doc/BRIEF.md
# Parallel Bit-Sliced LED String Transmitter

This block drives a group of single-wire serial LED strings side by side, one output pin per string, all in lockstep from one shared bit-cell timebase. Colour data is held in a bit-sliced buffer. Each word in the buffer covers one bit slot and holds one bit per string, so a single word read gives the current bit for every string at once. Software-side logic loads pixels through a write port that takes a string index, a pixel index and a 24-bit colour. It then pulses a start strobe with an enable mask and a pixel count, and waits for the done flag.

Every bit cell has three phases. At the start of the cell every enabled string goes high. At one third of the cell the strings sending a zero fall. At two thirds every string is low. A frame opens with two silent cells and closes with one. The block keeps the lines quiet for a guard time after each frame, so that the strings latch their data before the next frame begins. With the default parameters a cell is 60 clock cycles, the phase edges fall at cycles 20 and 40, and the guard is 2400 cycles (50 us at 48 MHz).

Top module: `strand_bitslice_tx`

## Requirements
- R1: A bit cell lasts CELL_TICKS clock cycles. The slots of a frame follow one another with no idle cycle between them.
- R2: In a data cell, each enabled string is high for cell cycles 0 to ZERO_TICKS-1. A string whose bit is 1 stays high until cycle ONE_TICKS-1. Every string is low from cycle ONE_TICKS to the end of the cell. All pins change on the same clock edge.
- R3: The colour input is packed as green in bits 23:16, red in 15:8 and blue in 7:0. Pixel p of a string fills data slots 24p to 24p+23 and carries colour bit 23-k in slot 24p+k. Pixels go out in ascending index order.
- R4: A pixel write changes only the addressed string's bit in the 24 slot words of that pixel. The other strings' data is left as it was.
- R5: The first cell of a frame starts no earlier than GUARD_TICKS cycles after the previous frame completed. When a start arrives on the cycle done is seen, the first data cell begins exactly GUARD_TICKS+1+2*CELL_TICKS cycles after the start is accepted.
- R6: A frame opens with two all-low padding cells and ends with one. With the guard already expired, the first data cell begins 2+2*CELL_TICKS cycles after the start is accepted.
- R7: The pixel count is taken at frame launch. A count above MAX_PIX sends MAX_PIX pixels. A count of 0 sends only the three padding cells, all low.
- R8: Strings outside the enable mask stay low. All outputs are low during reset, between frames and in padding cells.
- R9: busy rises on the cycle after a start is accepted, and done clears on that same cycle. At frame completion, done rises and busy falls on the edge that emits the final padding cycle. done then stays high until the next start is accepted.
- R10: A start that arrives while busy, whether the block is waiting out the guard time or sending, is ignored. The enable mask and the pixel count are sampled once, when the guard expires. Later changes to them have no effect on the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pixel write strobe |
| wr_str | input | STR_W | String index of the write |
| wr_pix | input | PIX_W | Pixel index of the write |
| wr_rgb | input | 24 | Colour {green, red, blue} |
| start | input | 1 | Frame start strobe |
| en_mask | input | N_STR | Strings to drive in the next frame |
| pix_cnt | input | CNT_W | Pixels per string in the next frame |
| busy | output | 1 | Frame pending or in progress |
| done | output | 1 | Last frame completed |
| dout | output | N_STR | Serial data lines, one per string |

## Verification
The hardest case to reach from the ports is a start that lands while the guard timer is still counting. The bench covers it by driving start on the very cycle done is first observed, and then predicting the exact cycle of the first rising edge. It also pulses start during the guard wait and in the middle of a data cell, and changes the mask and count on that same cycle, to show that the snapshot holds. Colours and masks are drawn at random from a fixed seed and compared with a bench model of the bit-sliced buffer, slot by slot and cycle by cycle.

// File: rtl/lstx_pkg.sv
package lstx_pkg;
  localparam int unsigned BITS_PER_PIX = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_SEND = 2'd2
  } lstx_state_e;
endpackage

// File: rtl/lstx_slot_mem.sv
// Bit-sliced store: one word per data slot, one bit per string.
module lstx_slot_mem
  import lstx_pkg::*;
#(
  parameter int unsigned N_STR   = 8,
  parameter int unsigned MAX_PIX = 60,
  parameter int unsigned STR_W   = 3,
  parameter int unsigned PIX_W   = 6,
  parameter int unsigned ADDR_W  = 11
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [STR_W-1:0]        wr_str,
  input  logic [PIX_W-1:0]        wr_pix,
  input  logic [BITS_PER_PIX-1:0] wr_rgb,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [N_STR-1:0]        rd_word
);
  localparam int unsigned DEPTH = BITS_PER_PIX * MAX_PIX;

  logic [N_STR-1:0]  mem_q [DEPTH];
  logic              wr_ok;
  logic [ADDR_W-1:0] base;

  always_comb begin
    wr_ok = wr_en && (int'(wr_str) < int'(N_STR)) && (int'(wr_pix) < int'(MAX_PIX));
    base  = ADDR_W'(int'(wr_pix) * int'(BITS_PER_PIX));
  end

  // One pixel write touches 24 words, each at the addressed string's bit only.
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      for (int k = 0; k < int'(BITS_PER_PIX); k++) begin
        mem_q[base + ADDR_W'(k)][wr_str] <= wr_rgb[int'(BITS_PER_PIX) - 1 - k];
      end
    end
  end

  always_comb begin
    if (int'(rd_addr) < int'(DEPTH)) rd_word = mem_q[rd_addr];
    else                             rd_word = '0;
  end
endmodule

// File: rtl/lstx_guard.sv
// Counts cycles since the last frame completed; saturates at the guard length.
module lstx_guard #(
  parameter int unsigned GUARD_TICKS = 2400,
  parameter int unsigned GUARD_W     = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  logic [GUARD_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (restart)                              cnt_n = '0;
    else if (cnt_q < GUARD_W'(GUARD_TICKS))   cnt_n = cnt_q + GUARD_W'(1);
    else                                      cnt_n = cnt_q;
    expired = (cnt_q == GUARD_W'(GUARD_TICKS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assert_guard_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);
endmodule

// File: rtl/lstx_seq.sv
// Frame sequencer: start acceptance, guard hold, tick and slot counters.
module lstx_seq
  import lstx_pkg::*;
#(
  parameter int unsigned N_STR      = 8,
  parameter int unsigned MAX_PIX    = 60,
  parameter int unsigned CELL_TICKS = 60,
  parameter int unsigned PAD_HEAD   = 2,
  parameter int unsigned PAD_TAIL   = 1,
  parameter int unsigned CNT_W      = 6,
  parameter int unsigned SLOT_W     = 11,
  parameter int unsigned TICK_W     = 6,
  parameter int unsigned ADDR_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_STR-1:0]  mask_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              guard_ok,
  output logic              frame_end,
  output logic              send_act,
  output logic              in_data,
  output logic [TICK_W-1:0] tick,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [N_STR-1:0]  mask,
  output logic              busy,
  output logic              done
);
  lstx_state_e       state_q, state_n;
  logic [TICK_W-1:0] tick_q, tick_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic [SLOT_W-1:0] dend_q, dend_n;
  logic [N_STR-1:0]  mask_q, mask_n;
  logic              done_q, done_n;

  logic [CNT_W-1:0]  cnt_c;
  logic [SLOT_W-1:0] dend_c;
  logic [SLOT_W-1:0] last_slot;
  logic              cell_end;

  always_comb begin
    cnt_c     = (cnt_in > CNT_W'(MAX_PIX)) ? CNT_W'(MAX_PIX) : cnt_in;
    dend_c    = SLOT_W'(int'(PAD_HEAD) + int'(BITS_PER_PIX) * int'(cnt_c));
    last_slot = dend_q + SLOT_W'(PAD_TAIL) - SLOT_W'(1);
    cell_end  = (tick_q == TICK_W'(CELL_TICKS - 1));
  end

  // Next-state logic
  always_comb begin
    state_n   = state_q;
    tick_n    = tick_q;
    slot_n    = slot_q;
    dend_n    = dend_q;
    mask_n    = mask_q;
    done_n    = done_q;
    frame_end = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_HOLD;
          done_n  = 1'b0;
        end
      end
      ST_HOLD: begin
        if (guard_ok) begin
          state_n = ST_SEND;
          tick_n  = '0;
          slot_n  = '0;
          mask_n  = mask_in;
          dend_n  = dend_c;
        end
      end
      ST_SEND: begin
        if (cell_end) begin
          tick_n = '0;
          if (slot_q == last_slot) begin
            state_n   = ST_IDLE;
            done_n    = 1'b1;
            frame_end = 1'b1;
          end else begin
            slot_n = slot_q + SLOT_W'(1);
          end
        end else begin
          tick_n = tick_q + TICK_W'(1);
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      slot_q  <= '0;
      dend_q  <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      tick_q  <= tick_n;
      slot_q  <= slot_n;
      dend_q  <= dend_n;
      mask_q  <= mask_n;
      done_q  <= done_n;
    end
  end

  always_comb begin
    send_act = (state_q == ST_SEND);
    in_data  = (slot_q >= SLOT_W'(PAD_HEAD)) && (slot_q < dend_q);
    tick     = tick_q;
    rd_addr  = ADDR_W'(slot_q - SLOT_W'(PAD_HEAD));
    mask     = mask_q;
    busy     = (state_q != ST_IDLE);
    done     = done_q;
  end

  assert_tick_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < TICK_W'(CELL_TICKS));

  assert_guard_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !guard_ok) |=> (state_q == ST_HOLD));

  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(state_q) == ST_SEND));

  assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && $past(state_q) == ST_SEND) |-> $stable(mask_q));
endmodule

// File: rtl/lstx_wave.sv
// Three-phase cell shaper with a registered output stage shared by all strings.
module lstx_wave #(
  parameter int unsigned N_STR      = 8,
  parameter int unsigned ZERO_TICKS = 20,
  parameter int unsigned ONE_TICKS  = 40,
  parameter int unsigned TICK_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_act,
  input  logic              in_data,
  input  logic [TICK_W-1:0] tick,
  input  logic [N_STR-1:0]  word,
  input  logic [N_STR-1:0]  mask,
  output logic [N_STR-1:0]  dout
);
  logic [N_STR-1:0] dout_q, dout_n;

  always_comb begin
    dout_n = '0;
    if (send_act && in_data) begin
      if (tick < TICK_W'(ZERO_TICKS))     dout_n = mask;
      else if (tick < TICK_W'(ONE_TICKS)) dout_n = mask & word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_n;
  end

  assign dout = dout_q;

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(send_act) |-> (dout_q == '0));

  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout_q & ~$past(mask)) == '0));

  assert_late_phase_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(send_act) && ($past(tick) >= TICK_W'(ONE_TICKS))) |-> (dout_q == '0));
endmodule

// File: rtl/strand_bitslice_tx.sv
module strand_bitslice_tx
  import lstx_pkg::*;
#(
  parameter int unsigned N_STR       = 8,
  parameter int unsigned MAX_PIX     = 60,
  parameter int unsigned CELL_TICKS  = 60,
  parameter int unsigned ZERO_TICKS  = 20,
  parameter int unsigned ONE_TICKS   = 40,
  parameter int unsigned GUARD_TICKS = 2400,
  parameter int unsigned PAD_HEAD    = 2,
  parameter int unsigned PAD_TAIL    = 1,
  localparam int unsigned STR_W   = (N_STR > 1) ? $clog2(N_STR) : 1,
  localparam int unsigned PIX_W   = (MAX_PIX > 1) ? $clog2(MAX_PIX) : 1,
  localparam int unsigned CNT_W   = $clog2(MAX_PIX + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [STR_W-1:0]        wr_str,
  input  logic [PIX_W-1:0]        wr_pix,
  input  logic [BITS_PER_PIX-1:0] wr_rgb,
  input  logic                    start,
  input  logic [N_STR-1:0]        en_mask,
  input  logic [CNT_W-1:0]        pix_cnt,
  output logic                    busy,
  output logic                    done,
  output logic [N_STR-1:0]        dout
);
  localparam int unsigned DATA_SLOTS = BITS_PER_PIX * MAX_PIX;
  localparam int unsigned ADDR_W     = $clog2(DATA_SLOTS);
  localparam int unsigned SLOT_W     = $clog2(PAD_HEAD + DATA_SLOTS + PAD_TAIL);
  localparam int unsigned TICK_W     = $clog2(CELL_TICKS);
  localparam int unsigned GUARD_W    = $clog2(GUARD_TICKS + 1);

  // Asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic              guard_ok, frame_end, send_act, in_data;
  logic [TICK_W-1:0] tick;
  logic [ADDR_W-1:0] rd_addr;
  logic [N_STR-1:0]  rd_word, mask;

  lstx_slot_mem #(
    .N_STR(N_STR), .MAX_PIX(MAX_PIX), .STR_W(STR_W), .PIX_W(PIX_W), .ADDR_W(ADDR_W)
  ) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_str(wr_str), .wr_pix(wr_pix), .wr_rgb(wr_rgb),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  lstx_guard #(.GUARD_TICKS(GUARD_TICKS), .GUARD_W(GUARD_W)) u_guard (
    .clk(clk), .rst_n(rst_ni), .restart(frame_end), .expired(guard_ok)
  );

  lstx_seq #(
    .N_STR(N_STR), .MAX_PIX(MAX_PIX), .CELL_TICKS(CELL_TICKS), .PAD_HEAD(PAD_HEAD),
    .PAD_TAIL(PAD_TAIL), .CNT_W(CNT_W), .SLOT_W(SLOT_W), .TICK_W(TICK_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_ni), .start(start), .mask_in(en_mask), .cnt_in(pix_cnt),
    .guard_ok(guard_ok), .frame_end(frame_end), .send_act(send_act), .in_data(in_data),
    .tick(tick), .rd_addr(rd_addr), .mask(mask), .busy(busy), .done(done)
  );

  lstx_wave #(
    .N_STR(N_STR), .ZERO_TICKS(ZERO_TICKS), .ONE_TICKS(ONE_TICKS), .TICK_W(TICK_W)
  ) u_wave (
    .clk(clk), .rst_n(rst_ni), .send_act(send_act), .in_data(in_data), .tick(tick),
    .word(rd_word), .mask(mask), .dout(dout)
  );
endmodule

// File: tb/sim_strand_bitslice_tx.sv
module sim_strand_bitslice_tx;
  localparam int NS = 4;
  localparam int MP = 8;
  localparam int CT = 6;
  localparam int ZT = 2;
  localparam int OT = 4;
  localparam int GT = 40;
  localparam int SW = 2;
  localparam int PW = 3;
  localparam int CW = $clog2(MP + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, wr_en, start, busy, done;
  logic [SW-1:0] wr_str;
  logic [PW-1:0] wr_pix;
  logic [23:0]   wr_rgb;
  logic [NS-1:0] en_mask, dout;
  logic [CW-1:0] pix_cnt;

  strand_bitslice_tx #(
    .N_STR(NS), .MAX_PIX(MP), .CELL_TICKS(CT), .ZERO_TICKS(ZT), .ONE_TICKS(OT),
    .GUARD_TICKS(GT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_str(wr_str), .wr_pix(wr_pix),
    .wr_rgb(wr_rgb), .start(start), .en_mask(en_mask), .pix_cnt(pix_cnt),
    .busy(busy), .done(done), .dout(dout)
  );

  logic [23:0] model [NS][MP];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected line levels for sample i of a frame whose slot 0 appears at sample s0
  function automatic logic [NS-1:0] exp_out(input int i, input int s0, input logic [NS-1:0] m, input int c);
    logic [NS-1:0] r;
    int rel, k, t, p, b;
    r = '0;
    rel = i - s0 - 2 * CT;
    if (rel < 0 || rel >= 24 * c * CT) return r;
    k = rel / CT;
    t = rel % CT;
    p = k / 24;
    b = 23 - (k % 24);
    for (int s = 0; s < NS; s++) begin
      if (t < ZT)      r[s] = m[s];
      else if (t < OT) r[s] = m[s] & model[s][p][b];
      else             r[s] = 1'b0;
    end
    return r;
  endfunction

  task automatic write_px(input int s, input int p, input logic [23:0] rgb);
    wr_en = 1'b1; wr_str = SW'(s); wr_pix = PW'(p); wr_rgb = rgb;
    model[s][p] = rgb;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Called at a negedge; returns at the negedge where done is expected.
  task automatic frame(input logic [NS-1:0] m, input int cnt_req, input int s0,
                       input int poke_start, input int poke_cfg, input string tag);
    int c, dix, wbad, sbad, wact, wexp, sact, sexp;
    logic [NS-1:0] ex;
    c = (cnt_req > MP) ? MP : cnt_req;
    dix = s0 + (3 + 24 * c) * CT - 1;
    wbad = 0; sbad = 0; wact = 0; wexp = 0; sact = 0; sexp = 0;
    en_mask = m; pix_cnt = CW'(cnt_req); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && busy == 1'b1, "R9", "accept: {done,busy}", {done, busy}, 1);
    for (int i = 0; i <= dix; i++) begin
      if (i > 0) @(negedge clk);
      ex = exp_out(i, s0, m, c);
      if (dout !== ex) begin
        if (wbad == 0) begin wact = int'(dout); wexp = int'(ex); end
        wbad++;
      end
      if ({busy, done} !== ((i < dix) ? 2'b10 : 2'b01)) begin
        if (sbad == 0) begin sact = i; sexp = dix; end
        sbad++;
      end
      start = (i == poke_start) ? 1'b1 : 1'b0;
      if (i == poke_cfg) begin en_mask = ~m; pix_cnt = CW'(MP); end
    end
    start = 1'b0;
    check(wbad == 0, tag, "line pattern (first bad sample)", wact, wexp);
    check(sbad == 0, "R9", "busy/done timing, sample index", sact, sexp);
  endtask

  task automatic idle_check(input int n, input string tag);
    int nb;
    nb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dout !== '0 || busy !== 1'b0) nb++;
    end
    check(nb == 0, tag, "quiet samples with activity", nb, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; wr_str = '0; wr_pix = '0; wr_rgb = '0;
    en_mask = '0; pix_cnt = '0;
    repeat (3) @(negedge clk);
    check(dout == '0 && busy == 1'b0 && done == 1'b0, "R8", "reset state {dout,busy,done}",
          int'({dout, busy, done}), 0);
    rst_n = 1'b1;
    repeat (GT + 10) @(negedge clk);

    for (int s = 0; s < NS; s++)
      for (int p = 0; p < MP; p++)
        write_px(s, p, 24'($urandom));

    // R1: basic frame, all strings
    frame(4'b1111, 2, 2, -1, -1, "R1");
    idle_check(GT + 5, "R8");
    check(done == 1'b1, "R9", "done held while idle", int'(done), 1);

    // R3: directed colour ordering on string 0
    write_px(0, 0, 24'hA5_3C_81);
    frame(4'b0001, 1, 2, -1, -1, "R3");
    idle_check(GT + 5, "R8");

    // R4: single write affects only string 2
    write_px(2, 1, 24'hFF_00_F0);
    frame(4'b1111, 2, 2, -1, -1, "R4");
    idle_check(GT + 5, "R8");

    // R8: partial mask
    frame(4'b0101, 1, 2, -1, -1, "R8");
    // R5: back-to-back start waits out the guard; extra start during hold
    frame(4'b1011, 1, GT + 1, 3, -1, "R5");
    // R10: start and config changes mid-frame are ignored
    frame(4'b1110, 1, GT + 1, GT + 1 + 2 * CT + 5, GT + 1 + 2 * CT + 5, "R10");
    idle_check(GT + 20, "R10");

    // R6: padding lead with expired guard
    frame(4'b1111, 1, 2, -1, -1, "R6");
    idle_check(GT + 5, "R8");

    // R7: count clamp, then zero count back to back
    frame(4'b1010, 15, 2, -1, -1, "R7");
    frame(4'b1111, 0, GT + 1, -1, -1, "R7");
    idle_check(GT + 5, "R8");

    // Random frames (R2)
    for (int n = 0; n < 5; n++) begin
      for (int w = 0; w < 3; w++)
        write_px(int'($urandom % NS), int'($urandom % MP), 24'($urandom));
      frame(NS'($urandom), 1 + int'($urandom % 4), 2, -1, -1, "R2");
      idle_check(GT + 5, "R8");
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule